// File: doc/BRIEF.md
# Workload-Driven DVFS Governor

This block decides which of three voltage/frequency operating points a compute fabric runs at. It reads three inputs: how full the workload queue is, a die-temperature reading and a core-supply voltage reading. From these it drives three outputs: an operating-point index, a code for the external voltage regulator, and a one-hot select for a glitch-free clock multiplexer. The three points are low (50 MHz, 0.70 V), medium (100 MHz, 0.85 V) and high (200 MHz, 1.00 V).

The workload request uses two queue thresholds, and each threshold has hysteresis. A thermal throttle has its own trip and release levels. While the throttle is active it caps the fabric at a parameterised point (low by default) and drives gate enables to the non-critical blocks. A supply-droop detector caps the fabric at a second parameterised point (medium by default). The point put into effect is the lowest of the workload request and every active cap.

A sequencer orders each change so that the clock never runs faster than the regulator voltage supports. When raising, it moves the voltage first and waits a programmable settle time before moving the clock. When lowering, it moves the clock first and the voltage on the next cycle.

Top module: `dvfs_governor`

## Requirements
- R1: While reset is asserted, and after it is released, the outputs hold the low point: `op_idx` = 0, `vcode` = VC_LO (70), `clk_sel` = 3'b001, `busy` = 0 and `gate_en` = 0.
- R2: `op_idx` encodes low/medium/high as 0/1/2. `clk_sel` is one-hot, with bit 0 selecting 50 MHz, bit 1 selecting 100 MHz and bit 2 selecting 200 MHz, and it always equals 1 << `op_idx`. The settled `vcode` for points 0/1/2 is VC_LO/VC_MED/VC_HI (defaults 70/85/100).
- R3: The workload request is registered from `q_level`. The request goes to high when the level is at least 192, and stays high while the level is at least 128. Otherwise it is medium when the level is at least 64, or when it was already medium or high and the level is at least 32. Otherwise it is low.
- R4: A registered hot flag sets when `temp` > `temp_trip` and clears only when `temp` < `temp_release`. While the flag is set, the point is capped at THERM_CAP (0) and `gate_en` = GATE_MASK (4'b1101); otherwise `gate_en` = 0.
- R5: A registered droop flag equals (`vdd_meas` < `vdd_min`). While the flag is set, the point is capped at DROOP_CAP (1).
- R6: The target point is the minimum of the workload request and every active cap.
- R7: On a raise, `vcode` moves to the target's code on the edge the sequencer accepts the target. `op_idx` and `clk_sel` move `settle`+1 edges later.
- R8: On a lowering, `op_idx` and `clk_sel` move on the accepting edge, and `vcode` moves down on the following edge.
- R9: `busy` is high from the accepting edge until the change completes. A target that differs while `busy` is high is not acted on until `busy` is low again.
- R10: `vcode` is never below the code of the point given by `op_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Governor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q_level | input | QW (8) | Workload queue occupancy |
| temp | input | TW (10) | Die temperature reading |
| temp_trip | input | TW (10) | Level above which throttling begins |
| temp_release | input | TW (10) | Level below which throttling ends |
| vdd_meas | input | TW (10) | Measured core supply |
| vdd_min | input | TW (10) | Droop limit |
| settle | input | SW (8) | Voltage settle wait, in cycles |
| op_idx | output | 2 | Operating point in effect |
| vcode | output | VCW (8) | Regulator voltage code |
| clk_sel | output | 3 | One-hot clock-source select |
| busy | output | 1 | Transition in progress |
| gate_en | output | NG (4) | Gate enables for non-critical blocks |

## Verification
The assertions take for granted that `temp_release` is below `temp_trip`, so that the thermal hysteresis band is not empty. They also take for granted that the threshold and code parameters are ordered, which the elaboration checks enforce. The stimulus changes the sensor levels and `settle` only at falling edges. It keeps `settle` and `temp_release` fixed through each scenario, and it sets the queue level, temperature and supply both inside and outside each hysteresis band. A behavioural reference model in the bench compares all outputs on every cycle. That comparison covers changes of target that arrive during a transition.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;
   typedef enum logic [1:0] {
      OP_LOW  = 2'd0,
      OP_MED  = 2'd1,
      OP_HIGH = 2'd2
   } op_t;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_RAISE = 2'd1,
      SQ_LOWER = 2'd2
   } seq_t;

   function automatic op_t op_min(input op_t a, input op_t b);
      return (a < b) ? a : b;
   endfunction
endpackage

// File: rtl/wl_select.sv
module wl_select
   import dvfs_pkg::*;
#(
   parameter int QW      = 8,
   parameter int MED_ON  = 64,
   parameter int MED_OFF = 32,
   parameter int HI_ON   = 192,
   parameter int HI_OFF  = 128
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [QW-1:0] q_level,
   output op_t           req
);
   localparam logic [QW-1:0] L_MED_ON  = QW'(MED_ON);
   localparam logic [QW-1:0] L_MED_OFF = QW'(MED_OFF);
   localparam logic [QW-1:0] L_HI_ON   = QW'(HI_ON);
   localparam logic [QW-1:0] L_HI_OFF  = QW'(HI_OFF);

   op_t nxt;

   always_comb begin
      if (q_level >= L_HI_ON)
         nxt = OP_HIGH;
      else if (req == OP_HIGH && q_level >= L_HI_OFF)
         nxt = OP_HIGH;
      else if (q_level >= L_MED_ON)
         nxt = OP_MED;
      else if (req != OP_LOW && q_level >= L_MED_OFF)
         nxt = OP_MED;
      else
         nxt = OP_LOW;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req <= OP_LOW;
      else        req <= nxt;
   end
endmodule

// File: rtl/thermal_guard.sv
module thermal_guard #(
   parameter int TW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [TW-1:0] temp,
   input  logic [TW-1:0] temp_trip,
   input  logic [TW-1:0] temp_release,
   output logic          hot
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         hot <= 1'b0;
      else if (!hot && temp > temp_trip)
         hot <= 1'b1;
      else if (hot && temp < temp_release)
         hot <= 1'b0;
   end
endmodule

// File: rtl/dvfs_sequencer.sv
module dvfs_sequencer
   import dvfs_pkg::*;
#(
   parameter int VCW    = 8,
   parameter int SW     = 8,
   parameter int VC_LO  = 70,
   parameter int VC_MED = 85,
   parameter int VC_HI  = 100
) (
   input  logic           clk,
   input  logic           rst_n,
   input  op_t            target,
   input  logic [SW-1:0]  settle,
   output op_t            op,
   output logic [2:0]     clk_sel,
   output logic [VCW-1:0] vcode,
   output logic           busy
);
   seq_t          st;
   op_t           nxt;
   logic [SW-1:0] cnt;

   function automatic logic [VCW-1:0] code_of(input op_t p);
      case (p)
         OP_HIGH: return VCW'(VC_HI);
         OP_MED:  return VCW'(VC_MED);
         default: return VCW'(VC_LO);
      endcase
   endfunction

   assign busy = (st != SQ_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= SQ_IDLE;
         op      <= OP_LOW;
         nxt     <= OP_LOW;
         clk_sel <= 3'b001;
         vcode   <= VCW'(VC_LO);
         cnt     <= '0;
      end else begin
         case (st)
            SQ_IDLE: begin
               if (target > op) begin
                  vcode <= code_of(target);
                  nxt   <= target;
                  cnt   <= settle;
                  st    <= SQ_RAISE;
               end else if (target < op) begin
                  op      <= target;
                  clk_sel <= 3'b001 << target;
                  nxt     <= target;
                  st      <= SQ_LOWER;
               end
            end
            SQ_RAISE: begin
               if (cnt == '0) begin
                  op      <= nxt;
                  clk_sel <= 3'b001 << nxt;
                  st      <= SQ_IDLE;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            SQ_LOWER: begin
               vcode <= code_of(nxt);
               st    <= SQ_IDLE;
            end
            default: st <= SQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/dvfs_governor.sv
module dvfs_governor
   import dvfs_pkg::*;
#(
   parameter int          QW        = 8,
   parameter int          TW        = 10,
   parameter int          SW        = 8,
   parameter int          VCW       = 8,
   parameter int          NG        = 4,
   parameter logic [NG-1:0] GATE_MASK = 4'b1101,
   parameter int          MED_ON    = 64,
   parameter int          MED_OFF   = 32,
   parameter int          HI_ON     = 192,
   parameter int          HI_OFF    = 128,
   parameter int          VC_LO     = 70,
   parameter int          VC_MED    = 85,
   parameter int          VC_HI     = 100,
   parameter int          THERM_CAP = 0,
   parameter int          DROOP_CAP = 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [QW-1:0]  q_level,
   input  logic [TW-1:0]  temp,
   input  logic [TW-1:0]  temp_trip,
   input  logic [TW-1:0]  temp_release,
   input  logic [TW-1:0]  vdd_meas,
   input  logic [TW-1:0]  vdd_min,
   input  logic [SW-1:0]  settle,
   output logic [1:0]     op_idx,
   output logic [VCW-1:0] vcode,
   output logic [2:0]     clk_sel,
   output logic           busy,
   output logic [NG-1:0]  gate_en
);
   localparam op_t T_CAP = op_t'(THERM_CAP);
   localparam op_t D_CAP = op_t'(DROOP_CAP);

   if (!(MED_OFF < MED_ON && MED_ON <= HI_OFF && HI_OFF < HI_ON && HI_ON < (1 << QW)))
   begin : g_bad_queue
      $error("queue thresholds out of order or too wide");
   end
   if (!(VC_LO < VC_MED && VC_MED < VC_HI && VC_HI < (1 << VCW))) begin : g_bad_codes
      $error("voltage codes must rise with the point");
   end
   if (THERM_CAP < 0 || THERM_CAP > 2 || DROOP_CAP < 0 || DROOP_CAP > 2) begin : g_bad_caps
      $error("caps must name an existing point");
   end

   op_t  wl_req, target, op;
   logic hot, droop;

   wl_select #(
      .QW(QW), .MED_ON(MED_ON), .MED_OFF(MED_OFF), .HI_ON(HI_ON), .HI_OFF(HI_OFF)
   ) u_wl (
      .clk(clk), .rst_n(rst_n), .q_level(q_level), .req(wl_req)
   );

   thermal_guard #(.TW(TW)) u_therm (
      .clk(clk), .rst_n(rst_n), .temp(temp), .temp_trip(temp_trip),
      .temp_release(temp_release), .hot(hot)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) droop <= 1'b0;
      else        droop <= (vdd_meas < vdd_min);
   end

   always_comb begin
      target = wl_req;
      if (hot)   target = op_min(target, T_CAP);
      if (droop) target = op_min(target, D_CAP);
   end

   dvfs_sequencer #(
      .VCW(VCW), .SW(SW), .VC_LO(VC_LO), .VC_MED(VC_MED), .VC_HI(VC_HI)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .target(target), .settle(settle),
      .op(op), .clk_sel(clk_sel), .vcode(vcode), .busy(busy)
   );

   assign op_idx = op;

   for (genvar g = 0; g < NG; g++) begin : g_gate
      if (GATE_MASK[g]) begin : g_on
         assign gate_en[g] = hot;
      end else begin : g_off
         assign gate_en[g] = 1'b0;
      end
   end
endmodule

// File: rtl/dvfs_governor_chk.sv
module dvfs_governor_chk #(
   parameter int TW     = 10,
   parameter int VCW    = 8,
   parameter int NG     = 4,
   parameter int VC_LO  = 70,
   parameter int VC_MED = 85,
   parameter int VC_HI  = 100
) (
   input logic           clk,
   input logic           rst_n,
   input logic [TW-1:0]  temp,
   input logic [TW-1:0]  temp_trip,
   input logic [1:0]     op_idx,
   input logic [VCW-1:0] vcode,
   input logic [2:0]     clk_sel,
   input logic           busy,
   input logic [NG-1:0]  gate_en
);
   function automatic logic [VCW-1:0] need(input logic [1:0] p);
      case (p)
         2'd2:    return VCW'(VC_HI);
         2'd1:    return VCW'(VC_MED);
         default: return VCW'(VC_LO);
      endcase
   endfunction

   // R1
   reset_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (op_idx == 2'd0 && clk_sel == 3'b001));

   // R2
   sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(clk_sel) && clk_sel == (3'b001 << op_idx));

   // R4
   gate_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_en != '0) |-> $past(temp) > $past(temp_trip));

   // R7
   volt_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_idx > $past(op_idx)) |-> ($past(vcode) == need(op_idx)));

   // R8
   clk_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vcode < $past(vcode)) |-> (op_idx == $past(op_idx) && vcode == need(op_idx)));

   // R9
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(op_idx));

   // R10
   volt_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vcode >= need(op_idx));
endmodule

bind dvfs_governor dvfs_governor_chk #(
   .TW(TW), .VCW(VCW), .NG(NG), .VC_LO(VC_LO), .VC_MED(VC_MED), .VC_HI(VC_HI)
) u_chk (
   .clk(clk), .rst_n(rst_n), .temp(temp), .temp_trip(temp_trip),
   .op_idx(op_idx), .vcode(vcode), .clk_sel(clk_sel), .busy(busy), .gate_en(gate_en)
);

// File: tb/sim_dvfs_governor.sv
`timescale 1ns/1ps
module sim_dvfs_governor;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] q_level = '0;
   logic [9:0] temp = 10'd500, temp_trip = 10'd700, temp_release = 10'd650;
   logic [9:0] vdd_meas = 10'd1000, vdd_min = 10'd900;
   logic [7:0] settle = 8'd3;
   logic [1:0] op_idx;
   logic [7:0] vcode;
   logic [2:0] clk_sel;
   logic       busy;
   logic [3:0] gate_en;

   int total = 0, bad = 0;
   bit done = 0;

   always #2 clk = ~clk;

   dvfs_governor u0 (
      .clk(clk), .rst_n(rst_n), .q_level(q_level), .temp(temp), .temp_trip(temp_trip),
      .temp_release(temp_release), .vdd_meas(vdd_meas), .vdd_min(vdd_min), .settle(settle),
      .op_idx(op_idx), .vcode(vcode), .clk_sel(clk_sel), .busy(busy), .gate_en(gate_en)
   );

   // reference model state
   int m_wl, m_hot, m_droop, m_op, m_vc, m_st, m_cnt, m_nxt;

   function automatic int vcf(input int p);
      return (p == 2) ? 100 : (p == 1) ? 85 : 70;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_wl = 0; m_hot = 0; m_droop = 0; m_op = 0; m_vc = 70;
         m_st = 0; m_cnt = 0; m_nxt = 0;
      end else begin
         int tgt, w;
         tgt = m_wl;
         if (m_hot != 0 && tgt > 0) tgt = 0;
         if (m_droop != 0 && tgt > 1) tgt = 1;
         if (m_st == 0) begin
            if (tgt > m_op) begin
               m_vc = vcf(tgt); m_nxt = tgt; m_cnt = settle; m_st = 1;
            end else if (tgt < m_op) begin
               m_op = tgt; m_nxt = tgt; m_st = 2;
            end
         end else if (m_st == 1) begin
            if (m_cnt == 0) begin m_op = m_nxt; m_st = 0; end
            else m_cnt = m_cnt - 1;
         end else begin
            m_vc = vcf(m_nxt); m_st = 0;
         end
         if (q_level >= 192) w = 2;
         else if (m_wl == 2 && q_level >= 128) w = 2;
         else if (q_level >= 64) w = 1;
         else if (m_wl != 0 && q_level >= 32) w = 1;
         else w = 0;
         m_wl = w;
         if (m_hot == 0 && temp > temp_trip) m_hot = 1;
         else if (m_hot != 0 && temp < temp_release) m_hot = 0;
         m_droop = (vdd_meas < vdd_min) ? 1 : 0;
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      chk("R6", "op_idx vs model", op_idx, m_op);
      chk("R7", "vcode vs model", vcode, m_vc);
      chk("R2", "clk_sel", clk_sel, 1 << m_op);
      chk("R9", "busy vs model", busy, (m_st != 0) ? 1 : 0);
      chk("R4", "gate_en vs model", gate_en, (m_hot != 0) ? 13 : 0);
      chk("R10", "vcode floor", (vcode >= vcf(op_idx)) ? 1 : 0, 1);
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   initial begin
      #400000;
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      run(3);
      chk("R1", "reset op", op_idx, 0);
      chk("R1", "reset vcode", vcode, 70);
      chk("R1", "reset sel", clk_sel, 1);
      @(negedge clk); rst_n = 1'b1;
      run(2);
      chk("R1", "post-reset op", op_idx, 0);
      chk("R1", "post-reset busy", busy, 0);
      chk("R1", "post-reset gate", gate_en, 0);

      // medium request
      q_level = 8'd100; run(10);
      chk("R3", "medium at 100", op_idx, 1);
      chk("R2", "medium code", vcode, 85);

      // raise to high, then drop request during busy
      q_level = 8'd200; run(2);
      chk("R9", "busy during raise", busy, 1);
      chk("R7", "voltage raised first", vcode, 100);
      chk("R7", "clock not yet raised", op_idx, 1);
      q_level = 8'd10; run(4);
      chk("R9", "raise completes despite new request", op_idx, 2);
      chk("R9", "busy done", busy, 0);
      run(1);
      chk("R8", "clock lowered first", op_idx, 0);
      chk("R8", "voltage still high", vcode, 100);
      run(1);
      chk("R8", "voltage lowered next", vcode, 70);

      // queue hysteresis
      q_level = 8'd200; run(12);
      chk("R3", "high at 200", op_idx, 2);
      q_level = 8'd150; run(8);
      chk("R3", "high held at 150", op_idx, 2);
      q_level = 8'd100; run(8);
      chk("R3", "medium at 100", op_idx, 1);
      q_level = 8'd50; run(8);
      chk("R3", "medium held at 50", op_idx, 1);
      q_level = 8'd40; run(8);
      chk("R3", "medium held at 40", op_idx, 1);
      q_level = 8'd20; run(8);
      chk("R3", "low at 20", op_idx, 0);
      q_level = 8'd50; run(8);
      chk("R3", "low held at 50", op_idx, 0);
      q_level = 8'd200; run(12);

      // thermal
      temp = 10'd720; run(6);
      chk("R4", "throttled to low", op_idx, 0);
      chk("R4", "gates on", gate_en, 13);
      temp = 10'd680; run(8);
      chk("R4", "throttle held in band", op_idx, 0);
      temp = 10'd600; run(12);
      chk("R4", "released", op_idx, 2);
      chk("R4", "gates off", gate_en, 0);

      // droop and combination
      vdd_meas = 10'd850; run(6);
      chk("R5", "droop cap medium", op_idx, 1);
      temp = 10'd720; run(6);
      chk("R6", "thermal below droop", op_idx, 0);
      temp = 10'd600; run(10);
      chk("R6", "droop only", op_idx, 1);
      vdd_meas = 10'd1000; run(10);
      chk("R5", "droop cleared", op_idx, 2);

      // zero settle and longer settle
      settle = 8'd0; q_level = 8'd0; run(6);
      q_level = 8'd200; run(2);
      chk("R7", "zero settle: voltage up", vcode, 100);
      run(1);
      chk("R7", "zero settle: clock up next edge", op_idx, 2);
      settle = 8'd9; q_level = 8'd0; run(6);
      q_level = 8'd100; run(20);
      chk("R7", "long settle reaches medium", op_idx, 1);

      // reset mid-run
      rst_n = 1'b0; run(2);
      chk("R1", "reset again", op_idx, 0);
      rst_n = 1'b1; run(4);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule